// File: doc/BRIEF.md
# Sample-Rate Classifier with Lock Detection

This block watches a frame-sync pulse and measures the frame period by counting cycles of a fixed reference clock between consecutive pulses. Each measured period is judged: it must lie between a shortest and a longest allowed period, and it must agree with the previous in-range period within a small jitter allowance. A run of consecutive good periods declares lock. One bad period, or a silence longer than the longest allowed period, drops lock at once.

Good periods also drive a high-rate indicator with hysteresis. A short period, meaning a fast frame rate at or above roughly 88.2 kHz, sets the indicator. A long period, meaning a slow frame rate at or below roughly 54 kHz, clears it. Periods in the band between the two thresholds leave the indicator unchanged. All thresholds are parameters in reference-clock counts. The defaults assume a 24.576 MHz reference and accept frame rates from 22 kHz to 108 kHz.

Top module: `sr_rate_classifier`

## Requirements
- R1: While the synchronous reset `rst_i` is high, and after it is released, `unlock_o` is 1 and `high_rate_o` is 0. No period reference is held.
- R2: Each clock edge at which `fsync_i` is sampled high is a sync event. The period is the number of clock edges from one sync event to the next. The first sync event after reset only starts a measurement and is not judged.
- R3: A period below `MIN_PERIOD` or above `MAX_PERIOD` is bad. `unlock_o` is 1 from the next cycle, the good-period run restarts, and no reference is kept for R4.
- R4: An in-range period that differs from the previous in-range period by more than `JITTER_TOL` is bad, with the consequences of R3, but it becomes the new reference. When no reference is held, any in-range period passes this test.
- R5: `unlock_o` falls in the cycle after the `LOCK_GOOD`-th consecutive good period, and it stays low while good periods continue.
- R6: If no sync event occurs on the `MAX_PERIOD` edges after a sync event, `unlock_o` is 1 after the `MAX_PERIOD`-th edge. The period measured by the next sync event then counts as out of range.
- R7: A good period of at most `FAST_MAX` sets `high_rate_o` to 1 in the next cycle.
- R8: A good period of at least `SLOW_MIN` clears `high_rate_o` to 0 in the next cycle.
- R9: A good period strictly between `FAST_MAX` and `SLOW_MIN` leaves `high_rate_o` unchanged. Bad periods, timeouts and idle cycles never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fixed reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | Frame-sync pulse, synchronous to `clk_i` |
| high_rate_o | output | 1 | High-rate indicator with hysteresis |
| unlock_o | output | 1 | 1 when the sync stream is not qualified |

## Verification
The bench builds the block with small counts: `MIN_PERIOD`=20, `FAST_MAX`=40, `SLOW_MIN`=80, `MAX_PERIOD`=200, `JITTER_TOL`=3 and `LOCK_GOOD`=4. With these values, every boundary period (19, 20, 40, 41, 79, 80, 200 and a timeout at 201) is reached within a few hundred cycles, and lock is qualified in only a handful of frames. This makes it cheap to move between fast, middle-band and slow rates many times, and to hit jitter just inside the tolerance and jumps just outside it.

// File: rtl/sr_pkg.sv
package sr_pkg;

    // Widest period the block can represent, in reference-clock counts.
    localparam int SR_PW = 16;

    typedef logic [SR_PW-1:0] period_t;

    // What happened on the sync input in the current cycle.
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_START   = 2'd1,
        EV_SYNC    = 2'd2,
        EV_TIMEOUT = 2'd3
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e kind;
        period_t  period;
    } frame_ev_t;

    // Judgement of one frame event.
    typedef struct packed {
        logic    good;    // in range and regular
        logic    fault;   // drops lock
        period_t period;
    } verdict_t;

    typedef enum logic [1:0] {
        RC_SLOW = 2'd0,
        RC_MID  = 2'd1,
        RC_FAST = 2'd2
    } rate_class_e;

    function automatic period_t abs_diff(period_t a, period_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic logic in_window(period_t p, period_t lo, period_t hi);
        return (p >= lo) && (p <= hi);
    endfunction

    function automatic rate_class_e classify(period_t p, period_t fast_max,
                                             period_t slow_min);
        if (p <= fast_max) return RC_FAST;
        if (p >= slow_min) return RC_SLOW;
        return RC_MID;
    endfunction

endpackage

// File: rtl/sr_period_counter.sv
module sr_period_counter
    import sr_pkg::*;
#(
    parameter int MAX_PERIOD = 1117
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      fsync_i,
    output frame_ev_t ev_o
);
    localparam period_t LIMIT = period_t'(MAX_PERIOD);
    localparam period_t SAT   = period_t'(MAX_PERIOD + 1);

    // 0 = no sync seen yet; otherwise edges since the last sync (saturating).
    period_t cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt <= '0;
        end else if (fsync_i) begin
            cnt <= period_t'(1);
        end else if (cnt != '0 && cnt != SAT) begin
            cnt <= cnt + period_t'(1);
        end
    end

    always_comb begin
        ev_o.period = cnt;
        if (fsync_i) begin
            ev_o.kind = (cnt == '0) ? EV_START : EV_SYNC;
        end else if (cnt == LIMIT) begin
            ev_o.kind = EV_TIMEOUT;
        end else begin
            ev_o.kind = EV_IDLE;
        end
    end

    // A silence raises exactly one timeout event.
    AST_TIMEOUT_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_o.kind == EV_TIMEOUT) |=> (ev_o.kind != EV_TIMEOUT)); // R6

    // A measured period is never zero.
    AST_SYNC_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_o.kind == EV_SYNC) |-> (ev_o.period != '0)); // R2

endmodule

// File: rtl/sr_interval_judge.sv
module sr_interval_judge
    import sr_pkg::*;
#(
    parameter int MIN_PERIOD = 227,
    parameter int MAX_PERIOD = 1117,
    parameter int JITTER_TOL = 4
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  frame_ev_t ev_i,
    output verdict_t  v_o
);
    localparam period_t LO  = period_t'(MIN_PERIOD);
    localparam period_t HI  = period_t'(MAX_PERIOD);
    localparam period_t TOL = period_t'(JITTER_TOL);

    period_t ref_q;
    logic    ref_ok_q;
    logic    in_range;
    logic    regular;
    logic    is_sync;

    always_comb begin
        is_sync  = (ev_i.kind == EV_SYNC);
        in_range = in_window(ev_i.period, LO, HI);
        regular  = !ref_ok_q || (abs_diff(ev_i.period, ref_q) <= TOL);
        v_o.period = ev_i.period;
        v_o.good   = is_sync && in_range && regular;
        v_o.fault  = (is_sync && !(in_range && regular)) ||
                     (ev_i.kind == EV_TIMEOUT);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ref_q    <= '0;
            ref_ok_q <= 1'b0;
        end else begin
            unique case (ev_i.kind)
                EV_SYNC: begin
                    ref_ok_q <= in_range;
                    if (in_range) ref_q <= ev_i.period;
                end
                EV_TIMEOUT: ref_ok_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // The opening sync after reset is never judged good.
    AST_START_UNJUDGED: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_i.kind == EV_START) |-> !v_o.good && !v_o.fault); // R2

    AST_RANGE_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_i.kind == EV_SYNC && (ev_i.period < LO || ev_i.period > HI))
        |-> v_o.fault); // R3

    AST_JUMP_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_i.kind == EV_SYNC && ref_ok_q && abs_diff(ev_i.period, ref_q) > TOL)
        |-> v_o.fault); // R4

    AST_GOOD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !(v_o.good && v_o.fault)); // R4

endmodule

// File: rtl/sr_lock_tracker.sv
module sr_lock_tracker #(
    parameter int LOCK_GOOD = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic good_i,
    input  logic fault_i,
    output logic unlock_o
);
    localparam int RUN_W = (LOCK_GOOD < 2) ? 1 : $clog2(LOCK_GOOD + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_GOOD);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (fault_i) begin
            run_q <= '0;
        end else if (good_i && run_q != RUN_FULL) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    assign unlock_o = (run_q != RUN_FULL);

    AST_UNLOCK_AFTER_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_i |=> unlock_o); // R3

    AST_LOCK_ONLY_ON_GOOD: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(unlock_o) |-> $past(good_i)); // R5

    AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!unlock_o && good_i) |=> !unlock_o); // R5

endmodule

// File: rtl/sr_rate_hyst.sv
module sr_rate_hyst
    import sr_pkg::*;
#(
    parameter int FAST_MAX = 278,
    parameter int SLOW_MIN = 456
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    good_i,
    input  period_t period_i,
    output logic    high_o
);
    localparam period_t FMAX = period_t'(FAST_MAX);
    localparam period_t SMIN = period_t'(SLOW_MIN);

    rate_class_e cls;

    always_comb cls = classify(period_i, FMAX, SMIN);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            high_o <= 1'b0;
        end else if (good_i) begin
            unique case (cls)
                RC_FAST: high_o <= 1'b1;
                RC_SLOW: high_o <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_HR_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        (good_i && period_i <= FMAX) |=> high_o); // R7

    AST_HR_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (good_i && period_i >= SMIN) |=> !high_o); // R8

    AST_HR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!good_i || (period_i > FMAX && period_i < SMIN)) |=> $stable(high_o)); // R9

endmodule

// File: rtl/sr_rate_classifier.sv
module sr_rate_classifier
    import sr_pkg::*;
#(
    parameter int REF_KHZ    = 24576, // reference clock, kHz
    parameter int MIN_PERIOD = 227,   // about 108 kHz
    parameter int FAST_MAX   = 278,   // about 88.2 kHz
    parameter int SLOW_MIN   = 456,   // about 54 kHz
    parameter int MAX_PERIOD = 1117,  // about 22 kHz
    parameter int JITTER_TOL = 4,
    parameter int LOCK_GOOD  = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic fsync_i,
    output logic high_rate_o,
    output logic unlock_o
);
    // Worst-case qualification: LOCK_GOOD+1 syncs at the slowest rate, in 20 ms.
    localparam longint LOCK_BUDGET = longint'(REF_KHZ) * 20;
    localparam longint LOCK_WORST  = longint'(LOCK_GOOD + 1) * MAX_PERIOD;

    initial begin : cfg_check
        assert (MIN_PERIOD >= 2 && MIN_PERIOD <= FAST_MAX && FAST_MAX < SLOW_MIN
                && SLOW_MIN <= MAX_PERIOD && MAX_PERIOD + 1 < (1 << SR_PW)
                && LOCK_GOOD >= 1 && LOCK_WORST < LOCK_BUDGET)
            else $error("sr_rate_classifier: inconsistent period parameters");
    end

    frame_ev_t ev;
    verdict_t  verdict;

    sr_period_counter #(
        .MAX_PERIOD (MAX_PERIOD)
    ) u_count (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .fsync_i (fsync_i),
        .ev_o    (ev)
    );

    sr_interval_judge #(
        .MIN_PERIOD (MIN_PERIOD),
        .MAX_PERIOD (MAX_PERIOD),
        .JITTER_TOL (JITTER_TOL)
    ) u_judge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ev_i  (ev),
        .v_o   (verdict)
    );

    sr_lock_tracker #(
        .LOCK_GOOD (LOCK_GOOD)
    ) u_lock (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .good_i   (verdict.good),
        .fault_i  (verdict.fault),
        .unlock_o (unlock_o)
    );

    sr_rate_hyst #(
        .FAST_MAX (FAST_MAX),
        .SLOW_MIN (SLOW_MIN)
    ) u_hyst (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .good_i   (verdict.good),
        .period_i (verdict.period),
        .high_o   (high_rate_o)
    );

    AST_RESET_STATE: assert property (@(posedge clk_i)
        $past(rst_i) |-> (unlock_o && !high_rate_o)); // R1

    AST_TIMEOUT_UNLOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev.kind == EV_TIMEOUT) |=> unlock_o); // R6

    AST_IDLE_NO_RATE_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        !fsync_i |=> $stable(high_rate_o)); // R9

endmodule

// File: tb/tb_sr_rate_classifier.sv
module tb_sr_rate_classifier;
    localparam int P_MIN  = 20;
    localparam int P_FAST = 40;
    localparam int P_SLOW = 80;
    localparam int P_MAX  = 200;
    localparam int P_TOL  = 3;
    localparam int P_LOCK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0;
    logic high_rate;
    logic unlock;

    always #2.5 clk = ~clk;

    sr_rate_classifier #(
        .REF_KHZ    (100),
        .MIN_PERIOD (P_MIN),
        .FAST_MAX   (P_FAST),
        .SLOW_MIN   (P_SLOW),
        .MAX_PERIOD (P_MAX),
        .JITTER_TOL (P_TOL),
        .LOCK_GOOD  (P_LOCK)
    ) dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .fsync_i     (fsync),
        .high_rate_o (high_rate),
        .unlock_o    (unlock)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string phase    = "R1";

    // Behavioural reference model, updated on each sampled edge.
    bit m_have = 0;
    int m_elapsed = 0;
    bit m_ref_ok = 0;
    int m_ref = 0;
    int m_run = 0;
    bit m_hr = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_have = 0; m_elapsed = 0; m_ref_ok = 0; m_ref = 0; m_run = 0; m_hr = 0;
        end else if (fsync) begin
            if (m_have) begin
                int  p;
                bit  inr, regl;
                p    = m_elapsed;
                inr  = (p >= P_MIN) && (p <= P_MAX);
                regl = !m_ref_ok || ((p > m_ref ? p - m_ref : m_ref - p) <= P_TOL);
                if (inr && regl) begin
                    if (m_run < P_LOCK) m_run++;
                    if (p <= P_FAST) m_hr = 1;
                    else if (p >= P_SLOW) m_hr = 0;
                end else begin
                    m_run = 0;
                end
                m_ref_ok = inr;
                if (inr) m_ref = p;
            end
            m_have = 1;
            m_elapsed = 1;
        end else if (m_have) begin
            if (m_elapsed == P_MAX) begin
                m_run = 0;
                m_ref_ok = 0;
            end
            if (m_elapsed <= P_MAX) m_elapsed++;
        end
    end

    task automatic check(bit ok, string req, int act, int exp, string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare the design against the model on every cycle.
    always @(negedge clk) begin
        if (!done) begin
            check(unlock === (m_run < P_LOCK), phase, int'(unlock),
                  int'(m_run < P_LOCK), "model unlock");
            check(high_rate === m_hr, phase, int'(high_rate), int'(m_hr),
                  "model high_rate");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Sync pulses spaced exactly p edges apart.
    task automatic pulses(int p, int n);
        for (int i = 0; i < n; i++) begin
            repeat (p - 1) @(negedge clk);
            fsync = 1'b1;
            @(negedge clk);
            fsync = 1'b0;
        end
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic expect_out(string req, bit exp_unlock, bit exp_hr);
        check(unlock === exp_unlock, req, int'(unlock), int'(exp_unlock), "unlock_o");
        check(high_rate === exp_hr, req, int'(high_rate), int'(exp_hr), "high_rate_o");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        phase = "R1";
        expect_out("R1", 1, 0);
        rst = 1'b0;
        idle(3);
        expect_out("R1", 1, 0);

        // First sync only opens; four good periods then lock.
        phase = "R2";
        pulses(30, 1);
        expect_out("R2", 1, 0);
        pulses(30, 3);
        expect_out("R5", 1, 1);
        pulses(30, 1);
        expect_out("R5", 0, 1);
        phase = "R7";
        expect_out("R7", 0, 1);

        // Jump 30 -> 60 is irregular.
        phase = "R4";
        pulses(60, 1);
        expect_out("R4", 1, 1);
        pulses(60, 4);
        expect_out("R9", 0, 1);

        // Slow rate clears the indicator.
        phase = "R8";
        pulses(120, 1);
        expect_out("R4", 1, 1);
        pulses(120, 1);
        expect_out("R8", 1, 0);
        pulses(120, 3);
        expect_out("R5", 0, 0);

        // Jitter inside the tolerance keeps lock.
        phase = "R4";
        pulses(123, 1);
        pulses(120, 1);
        pulses(117, 1);
        expect_out("R4", 0, 0);
        pulses(121, 1);
        expect_out("R4", 1, 0);

        // Middle band from a slow state holds the indicator low.
        phase = "R9";
        pulses(60, 1);
        pulses(60, 4);
        expect_out("R9", 0, 0);

        // Too-short period, then the shortest legal period.
        phase = "R3";
        pulses(15, 1);
        expect_out("R3", 1, 0);
        pulses(20, 1);
        expect_out("R3", 1, 1);
        pulses(20, 3);
        expect_out("R3", 0, 1);
        pulses(19, 1);
        expect_out("R3", 1, 1);

        // Longest legal period locks; then a silence times out.
        phase = "R6";
        pulses(200, 1);
        pulses(200, 4);
        expect_out("R3", 0, 0);
        idle(199);
        expect_out("R6", 0, 0);
        idle(1);
        expect_out("R6", 1, 0);
        idle(50);
        expect_out("R9", 1, 0);
        pulses(40, 1);
        expect_out("R6", 1, 0);

        // Fast boundary, then middle band, then slow boundary.
        phase = "R7";
        pulses(40, 4);
        expect_out("R7", 0, 1);
        phase = "R9";
        pulses(41, 2);
        expect_out("R9", 0, 1);
        phase = "R8";
        pulses(80, 1);
        expect_out("R4", 1, 1);
        pulses(80, 1);
        expect_out("R8", 1, 0);
        pulses(79, 1);
        expect_out("R9", 1, 0);

        // Reset in the middle of a locked run.
        phase = "R1";
        pulses(79, 3);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        expect_out("R1", 1, 0);
        pulses(50, 1);
        expect_out("R2", 1, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule